// File: doc/BRIEF.md
# External Register Bus Wait-State Controller

This block sits between a processor core and a 16-bit bus that reaches eight external register addresses. Numbered 0 to 7, these are the EXT slots. The core offers one access at a time, giving a slot index, a direction and write data. The controller turns that access into bus cycles. It holds the core with a stall signal for as long as the access is stretched.

Software sets the stretching through a 14-bit mapping register. It can give each of slots 0 to 6 one extra cycle for reads, for writes, or for both. Slot 7 is an on-chip register and is never stretched. A slow peripheral can add more cycles by holding the external wait input high.

A bus cycle is one clock, for example 50 ns at 20 MHz. One programmed wait state makes the access two clocks long (100 ns). The mapping is a single global setting, so software must rewrite it whenever the meaning of the slots changes.

Top module: `extbus_wait_ctrl`

## Requirements
- R1: After reset, `ready_o` is high, `stall_o`, `bus_rd_o`, `bus_wr_o` and `rvalid_o` are low, and the mapping register is all zeros, so no access gets a programmed wait state.
- R2: Bit `i` of the mapping register (bits 6..0) enables one wait state for reads of slot `i`. Bit `7+i` (bits 13..7) enables one wait state for writes to slot `i`. An enabled access with the wait input low lasts exactly two bus cycles.
- R3: Accesses to slot 7 never receive a programmed wait state, whatever the mapping register holds.
- R4: An access with no programmed wait and the wait input low lasts exactly one bus cycle, and `stall_o` stays low.
- R5: The wait input is sampled in every bus cycle of an access. The access completes in the first cycle in which the wait input is low and no programmed wait is still pending. Its level during the first cycle of a programmed-wait access does not change the length.
- R6: `stall_o` is high in every bus cycle of an access except the final one, and low outside accesses.
- R7: `bus_addr_o`, `bus_wdata_o` and the strobes hold their values from the first to the final cycle of an access.
- R8: For a read, `rdata_o` takes the value on `bus_rdata_i` in the final cycle of the access. `rvalid_o` is high for exactly the one cycle after it.
- R9: A write raises `bus_wr_o` as one contiguous pulse that covers the whole access, and `bus_rd_o` stays low. A read does the opposite. The two strobes are never high together.
- R10: A write to the mapping register applies from the next accepted access. An access already started keeps the wait setting it was accepted with.
- R11: A request is accepted only while `ready_o` is high. `ready_o` is low from the first to the final cycle of an access, and a request raised while it is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Write strobe for the mapping register |
| cfg_map_i | input | 14 | New mapping value: read enables in 6..0, write enables in 13..7 |
| req_i | input | 1 | Access request from the core |
| req_idx_i | input | 3 | Slot index of the requested access |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | 16 | Write data |
| ready_o | output | 1 | Controller idle, request will be accepted |
| stall_o | output | 1 | Access is being extended this cycle |
| rdata_o | output | 16 | Captured read data |
| rvalid_o | output | 1 | One-cycle pulse when `rdata_o` is updated |
| bus_addr_o | output | 3 | Bus slot address |
| bus_wdata_o | output | 16 | Bus write data |
| bus_rd_o | output | 1 | Bus read strobe |
| bus_wr_o | output | 1 | Bus write strobe |
| bus_rdata_i | input | 16 | Bus read data |
| bus_wait_i | input | 1 | External wait request |

## Verification
The bench changes bus read data in every cycle. A design that samples it too early or too late would return the value from the wrong cycle. It raises the wait input during the programmed wait cycle, because a design that added the two stretches together would make the access one cycle too long. It points fully enabled maps at slot 7 and uses single-bit maps, which catch a design that mixes up read and write bits or fails to exempt slot 7. It also rewrites the mapping in the middle of an access, which catches a design that reads the live register instead of the setting latched when the access was accepted. Finally, it raises requests while the controller is busy, which a design without proper gating would start as a phantom access.

// File: rtl/extbus_wait_pkg.sv
package extbus_wait_pkg;

    localparam int DEF_DATA_W = 16;
    localparam int DEF_NREGS  = 8;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_BASE = 2'd1,
        SEQ_PROG = 2'd2,
        SEQ_HOLD = 2'd3
    } seq_state_e;

    // Position of the read enable for a mapped slot.
    function automatic int rd_bit_pos(input int idx);
        return idx;
    endfunction

    // Position of the write enable; nmapped is the count of mapped slots.
    function automatic int wr_bit_pos(input int idx, input int nmapped);
        return nmapped + idx;
    endfunction

    function automatic logic seq_busy(input seq_state_e s);
        return s != SEQ_IDLE;
    endfunction

endpackage

// File: rtl/extbus_wait_map.sv
module extbus_wait_map
    import extbus_wait_pkg::*;
#(
    parameter int NREGS = DEF_NREGS,
    parameter int IDX_W = $clog2(NREGS),
    parameter int MAP_W = 2 * (NREGS - 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we_i,
    input  logic [MAP_W-1:0] cfg_map_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             wr_i,
    output logic             wait_en_o
);

    localparam int NMAPPED = NREGS - 1;
    localparam int NSLOT   = 1 << IDX_W;

    logic [MAP_W-1:0] map_q;
    logic [NSLOT-1:0] rd_en;
    logic [NSLOT-1:0] wr_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            map_q <= '0;
        end else if (cfg_we_i) begin
            map_q <= cfg_map_i;
        end
    end

    // The last slot is internal and every unused slot is never stretched.
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        if (g < NMAPPED) begin : g_mapped
            assign rd_en[g] = map_q[rd_bit_pos(g)];
            assign wr_en[g] = map_q[wr_bit_pos(g, NMAPPED)];
        end else begin : g_fixed
            assign rd_en[g] = 1'b0;
            assign wr_en[g] = 1'b0;
        end
    end

    assign wait_en_o = wr_i ? wr_en[idx_i] : rd_en[idx_i];

endmodule

// File: rtl/extbus_wait_seq.sv
module extbus_wait_seq
    import extbus_wait_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic go_i,
    input  logic prog_i,
    input  logic wait_i,
    output logic active_o,
    output logic stall_o,
    output logic done_o,
    output logic ready_o
);

    seq_state_e state_q;
    logic       prog_q;
    logic       prog_pending;

    assign active_o     = seq_busy(state_q);
    assign ready_o      = ~active_o;
    assign prog_pending = (state_q == SEQ_BASE) && prog_q;
    assign stall_o      = active_o && (prog_pending || wait_i);
    assign done_o       = active_o && !stall_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            prog_q  <= 1'b0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (go_i) begin
                        state_q <= SEQ_BASE;
                        prog_q  <= prog_i;
                    end
                end
                SEQ_BASE: begin
                    if (prog_q) begin
                        state_q <= SEQ_PROG;
                    end else if (wait_i) begin
                        state_q <= SEQ_HOLD;
                    end else begin
                        state_q <= SEQ_IDLE;
                    end
                end
                SEQ_PROG: begin
                    state_q <= wait_i ? SEQ_HOLD : SEQ_IDLE;
                end
                SEQ_HOLD: begin
                    state_q <= wait_i ? SEQ_HOLD : SEQ_IDLE;
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/extbus_wait_port.sv
module extbus_wait_port #(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              active_i,
    input  logic              done_i,
    input  logic [DATA_W-1:0] bus_rdata_i,
    output logic [IDX_W-1:0]  bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    output logic              bus_rd_o,
    output logic              bus_wr_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o
);

    logic [IDX_W-1:0]  addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              wr_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rvalid_q;
    logic              rd_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            wr_q    <= 1'b0;
        end else if (go_i) begin
            addr_q  <= idx_i;
            wdata_q <= wdata_i;
            wr_q    <= wr_i;
        end
    end

    assign rd_done = done_i && !wr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= rd_done;
            if (rd_done) begin
                rdata_q <= bus_rdata_i;
            end
        end
    end

    assign bus_addr_o  = addr_q;
    assign bus_wdata_o = wdata_q;
    assign bus_rd_o    = active_i && !wr_q;
    assign bus_wr_o    = active_i && wr_q;
    assign rdata_o     = rdata_q;
    assign rvalid_o    = rvalid_q;

endmodule

// File: rtl/extbus_wait_ctrl.sv
module extbus_wait_ctrl
    import extbus_wait_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int NREGS  = DEF_NREGS,
    parameter int IDX_W  = $clog2(NREGS),
    parameter int MAP_W  = 2 * (NREGS - 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we_i,
    input  logic [MAP_W-1:0]  cfg_map_i,
    input  logic              req_i,
    input  logic [IDX_W-1:0]  req_idx_i,
    input  logic              req_wr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              ready_o,
    output logic              stall_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o,
    output logic [IDX_W-1:0]  bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    output logic              bus_rd_o,
    output logic              bus_wr_o,
    input  logic [DATA_W-1:0] bus_rdata_i,
    input  logic              bus_wait_i
);

    logic go;
    logic wait_en;
    logic active;
    logic done;
    logic idle;

    assign go      = req_i && idle;
    assign ready_o = idle;

    extbus_wait_map #(
        .NREGS (NREGS),
        .IDX_W (IDX_W),
        .MAP_W (MAP_W)
    ) map_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_we_i  (cfg_we_i),
        .cfg_map_i (cfg_map_i),
        .idx_i     (req_idx_i),
        .wr_i      (req_wr_i),
        .wait_en_o (wait_en)
    );

    extbus_wait_seq seq_i (
        .clk      (clk),
        .rst      (rst),
        .go_i     (go),
        .prog_i   (wait_en),
        .wait_i   (bus_wait_i),
        .active_o (active),
        .stall_o  (stall_o),
        .done_o   (done),
        .ready_o  (idle)
    );

    extbus_wait_port #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) port_i (
        .clk         (clk),
        .rst         (rst),
        .go_i        (go),
        .idx_i       (req_idx_i),
        .wr_i        (req_wr_i),
        .wdata_i     (req_wdata_i),
        .active_i    (active),
        .done_i      (done),
        .bus_rdata_i (bus_rdata_i),
        .bus_addr_o  (bus_addr_o),
        .bus_wdata_o (bus_wdata_o),
        .bus_rd_o    (bus_rd_o),
        .bus_wr_o    (bus_wr_o),
        .rdata_o     (rdata_o),
        .rvalid_o    (rvalid_o)
    );

endmodule

// File: rtl/extbus_wait_chk.sv
module extbus_wait_chk #(
    parameter int DATA_W = 16,
    parameter int NREGS  = 8,
    parameter int IDX_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              ready_o,
    input logic              stall_o,
    input logic [DATA_W-1:0] rdata_o,
    input logic              rvalid_o,
    input logic [IDX_W-1:0]  bus_addr_o,
    input logic [DATA_W-1:0] bus_wdata_o,
    input logic              bus_rd_o,
    input logic              bus_wr_o,
    input logic [DATA_W-1:0] bus_rdata_i,
    input logic              bus_wait_i
);

    localparam logic [IDX_W-1:0] INT_IDX = IDX_W'(NREGS - 1);

    // R7
    hold_bus_chk: assert property (@(posedge clk) disable iff (rst)
        stall_o |=> $stable(bus_addr_o) && $stable(bus_wdata_o)
                    && $stable(bus_rd_o) && $stable(bus_wr_o));

    // R3
    int_nowait_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_o || bus_wr_o) && bus_addr_o == INT_IDX && !bus_wait_i |-> !stall_o);

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd_o && bus_wr_o));

    // R6
    stall_in_acc_chk: assert property (@(posedge clk) disable iff (rst)
        stall_o |-> (bus_rd_o || bus_wr_o) && !ready_o);

    // R5
    wait_extends_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_o || bus_wr_o) && bus_wait_i |-> stall_o);

    // R8
    rdata_capture_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rd_o && !stall_o |=> rvalid_o && rdata_o == $past(bus_rdata_i));

    // R11
    ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
        ready_o |-> !bus_rd_o && !bus_wr_o);

endmodule

bind extbus_wait_ctrl extbus_wait_chk #(
    .DATA_W (DATA_W),
    .NREGS  (NREGS),
    .IDX_W  (IDX_W)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .ready_o     (ready_o),
    .stall_o     (stall_o),
    .rdata_o     (rdata_o),
    .rvalid_o    (rvalid_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_rd_o    (bus_rd_o),
    .bus_wr_o    (bus_wr_o),
    .bus_rdata_i (bus_rdata_i),
    .bus_wait_i  (bus_wait_i)
);

// File: tb/extbus_wait_ctrl_tb_top.sv
`timescale 1ns/1ps
module extbus_wait_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we_i = 1'b0;
    logic [13:0] cfg_map_i = '0;
    logic        req_i = 1'b0;
    logic [2:0]  req_idx_i = '0;
    logic        req_wr_i = 1'b0;
    logic [15:0] req_wdata_i = '0;
    logic        ready_o, stall_o, rvalid_o, bus_rd_o, bus_wr_o;
    logic [15:0] rdata_o, bus_wdata_o;
    logic [2:0]  bus_addr_o;
    logic [15:0] bus_rdata_i = '0;
    logic        bus_wait_i = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    logic [13:0] exp_map = '0;

    always #2.5 clk = ~clk;

    extbus_wait_ctrl dut_i (
        .clk(clk), .rst(rst), .cfg_we_i(cfg_we_i), .cfg_map_i(cfg_map_i),
        .req_i(req_i), .req_idx_i(req_idx_i), .req_wr_i(req_wr_i),
        .req_wdata_i(req_wdata_i), .ready_o(ready_o), .stall_o(stall_o),
        .rdata_o(rdata_o), .rvalid_o(rvalid_o), .bus_addr_o(bus_addr_o),
        .bus_wdata_o(bus_wdata_o), .bus_rd_o(bus_rd_o), .bus_wr_o(bus_wr_o),
        .bus_rdata_i(bus_rdata_i), .bus_wait_i(bus_wait_i)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    function automatic bit exp_prog(input int idx, input bit wr);
        if (idx == 7) return 1'b0;
        return wr ? exp_map[7 + idx] : exp_map[idx];
    endfunction

    function automatic int exp_last(input bit prog, input int wcnt);
        return (wcnt > int'(prog)) ? wcnt : int'(prog);
    endfunction

    task automatic set_map(input logic [13:0] m);
        @(negedge clk);
        cfg_we_i  = 1'b1;
        cfg_map_i = m;
        @(negedge clk);
        cfg_we_i  = 1'b0;
        exp_map   = m;
    endtask

    // One access; wcnt = cycles from the start during which wait is held high.
    task automatic do_access(input int idx, input bit wr, input int wcnt,
                             input bit mid_cfg, input logic [13:0] new_map,
                             input bit poke);
        bit          prog = exp_prog(idx, wr);
        int          last = exp_last(prog, wcnt);
        logic [15:0] wd   = 16'($urandom);
        logic [15:0] cap  = '0;
        int          k    = 0;
        bit          len_ok = 1'b1;
        @(negedge clk);
        #1;
        check(ready_o == 1'b1, "R11", "ready before request", int'(ready_o), 1);
        req_i = 1'b1; req_idx_i = 3'(idx); req_wr_i = wr; req_wdata_i = wd;
        @(posedge clk);
        forever begin
            @(negedge clk);
            req_i       = poke && (k == 1);
            req_idx_i   = 3'($urandom);
            req_wdata_i = 16'($urandom);
            bus_wait_i  = (k < wcnt);
            bus_rdata_i = 16'($urandom);
            cfg_we_i    = mid_cfg && (k == 0);
            cfg_map_i   = new_map;
            #1;
            check(stall_o == (k < last), (k < last) ? "R6" : "R5",
                  $sformatf("stall in cycle %0d of idx %0d wr %0d", k, idx, wr),
                  int'(stall_o), int'(k < last));
            if (stall_o != (k < last)) len_ok = 1'b0;
            check(bus_addr_o == 3'(idx), "R7", "address held", int'(bus_addr_o), idx);
            check(bus_wr_o == wr && bus_rd_o == !wr, "R9", "strobe level",
                  int'({bus_wr_o, bus_rd_o}), int'({wr, !wr}));
            check(ready_o == 1'b0, "R11", "ready during access", int'(ready_o), 0);
            if (wr) check(bus_wdata_o == wd, "R7", "write data held",
                          int'(bus_wdata_o), int'(wd));
            if (k == last) begin
                cap = bus_rdata_i;
                break;
            end
            if (k > 40) begin
                len_ok = 1'b0;
                break;
            end
            k++;
        end
        check(len_ok, prog ? "R2" : "R4", $sformatf("access length idx %0d wr %0d", idx, wr),
              k + 1, last + 1);
        @(negedge clk);
        req_i = 1'b0; bus_wait_i = 1'b0; cfg_we_i = 1'b0;
        #1;
        check(!bus_rd_o && !bus_wr_o, "R9", "strobes drop after access",
              int'({bus_rd_o, bus_wr_o}), 0);
        check(ready_o == 1'b1, "R11", "ready after access", int'(ready_o), 1);
        check(rvalid_o == !wr, "R8", "rvalid pulse", int'(rvalid_o), int'(!wr));
        if (!wr) check(rdata_o == cap, "R8", "read data from final cycle",
                       int'(rdata_o), int'(cap));
        if (mid_cfg) exp_map = new_map;
        @(negedge clk);
        #1;
        check(rvalid_o == 1'b0, "R8", "rvalid one cycle", int'(rvalid_o), 0);
        if (poke) check(!bus_rd_o && !bus_wr_o, "R11", "request while busy ignored",
                        int'({bus_rd_o, bus_wr_o}), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = int'($urandom(32'd20240607));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check(ready_o == 1'b1 && stall_o == 1'b0, "R1", "ready/stall after reset",
              int'({ready_o, stall_o}), 2);
        check(!bus_rd_o && !bus_wr_o && !rvalid_o, "R1", "strobes after reset",
              int'({bus_rd_o, bus_wr_o, rvalid_o}), 0);
        // R1 R4: zero map, no waits
        for (int i = 0; i < 8; i++) begin
            do_access(i, 1'b0, 0, 1'b0, '0, 1'b0);
            do_access(i, 1'b1, 0, 1'b0, '0, 1'b0);
        end
        // R2 R3: all enabled, slot 7 exempt
        set_map(14'h3FFF);
        for (int i = 0; i < 8; i++) begin
            do_access(i, 1'b0, 0, 1'b0, '0, 1'b0);
            do_access(i, 1'b1, 0, 1'b0, '0, 1'b0);
        end
        // R2 layout: only write enable of slot 3 (bit 10)
        set_map(14'h0400);
        do_access(3, 1'b0, 0, 1'b0, '0, 1'b0);
        do_access(3, 1'b1, 0, 1'b0, '0, 1'b0);
        do_access(2, 1'b1, 0, 1'b0, '0, 1'b0);
        // R2 layout: only read enable of slot 5 (bit 5)
        set_map(14'h0020);
        do_access(5, 1'b0, 0, 1'b0, '0, 1'b0);
        do_access(5, 1'b1, 0, 1'b0, '0, 1'b0);
        // R5 wait input on top of programmed wait
        do_access(5, 1'b0, 1, 1'b0, '0, 1'b0);
        do_access(5, 1'b0, 3, 1'b0, '0, 1'b0);
        do_access(4, 1'b1, 2, 1'b0, '0, 1'b0);
        do_access(7, 1'b0, 4, 1'b0, '0, 1'b0);
        // R10: mid-access remap
        set_map(14'h0000);
        do_access(1, 1'b1, 0, 1'b1, 14'h3FFF, 1'b0);
        do_access(1, 1'b1, 0, 1'b0, '0, 1'b0);
        do_access(6, 1'b0, 0, 1'b1, 14'h0000, 1'b0);
        do_access(6, 1'b0, 0, 1'b0, '0, 1'b0);
        // R11: request while busy
        set_map(14'h3FFF);
        do_access(0, 1'b0, 3, 1'b0, '0, 1'b1);
        do_access(2, 1'b1, 0, 1'b0, '0, 1'b1);
        // Random mix
        for (int n = 0; n < 200; n++) begin
            int  idx  = int'($urandom % 8);
            bit  wr   = bit'($urandom % 2);
            int  wcnt = ($urandom % 3 == 0) ? int'($urandom % 5) : 0;
            bit  mid  = ($urandom % 10 == 0);
            if ($urandom % 8 == 0) set_map(14'($urandom));
            do_access(idx, wr, wcnt, mid, 14'($urandom), bit'($urandom % 6 == 0));
        end
        summary();
        $finish;
    end

endmodule